// File: doc/BRIEF.md
# Data-Move Microcontroller Core

This block is a compact 8-bit execution core that fetches bytes from an external program ROM and runs only data-transfer instructions. It holds an accumulator and a program counter, and it has an internal 256-byte data RAM. The lowest eight RAM bytes double as the working registers R0 to R7. The core supports three opcode shapes. The first has five opcode bits with a three-bit register number. The second has seven opcode bits with a one-bit pointer select (R0 or R1). The third is a full opcode byte, optionally followed by one operand byte.

The ROM read port is synchronous. The core drives an address, and the byte for that address arrives on the next clock. Each instruction byte occupies a fixed number of clocks, set by the parameter `CPB`: 12 for the slow classic pacing and 1 for the fast pacing. A one-cycle completion pulse marks the end of every instruction. This lets a surrounding bench or debugger sample the accumulator at instruction boundaries.

Top module: `movcore`

## Requirements
- R1: An active-high synchronous reset sets the accumulator to 0, clears `illegal` and `done`, and makes the core fetch its first byte from ROM address 0.
- R2: Reset leaves the data RAM unchanged. A value written before reset reads back unchanged afterwards.
- R3: Every instruction byte takes exactly `CPB` clocks, so consecutive `done` pulses are `CPB` times the byte length of the later instruction apart. One-byte forms are the register, indirect and illegal forms without an operand. All other forms are two bytes.
- R4: The program counter advances by one for each consumed byte, and `rom_addr` only ever holds still or steps by +1. At each `done` in classic pacing, `rom_addr` equals the total bytes consumed since reset.
- R5: Register forms, with nnn selecting Rn at RAM address n:
  - 11101nnn copies Rn into A.
  - 01111nnn loads Rn with the next byte.
  - 10101nnn copies RAM[next byte] into Rn.
  - 10001nnn copies Rn into RAM[next byte].
  - 11111nnn copies A into Rn.
- R6: Indirect forms, with bit 0 choosing pointer R0 or R1:
  - 1111011i writes A to RAM[Ri].
  - 1110011i copies RAM[Ri] into A.
  - 1010011i copies RAM[next byte] into RAM[Ri].
  - 1000011i copies RAM[Ri] into RAM[next byte].
- R7: Full-byte forms:
  - 0x74 loads A with the next byte.
  - 0xE5 copies RAM[next byte] into A.
  - 0xF5 copies A into RAM[next byte].
- R8: A direct-address write to addresses 0 to 7 changes the same storage that register forms read as R0 to R7.
- R9: Any other opcode is a one-byte no-operation. It leaves A and RAM unchanged and sets `illegal`, which stays set until reset.
- R10: `done` is high for one clock after each instruction completes, and the accumulator changes only in a clock where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | PC_W | Program ROM read address |
| rom_data | input | 8 | ROM byte for the address of the previous clock |
| acc | output | 8 | Accumulator |
| done | output | 1 | One-clock instruction-completion pulse |
| illegal | output | 1 | Sticky unsupported-opcode flag |

## Verification
A wrong byte phase or a program counter that is off by one makes the core read an operand as an opcode, or the reverse. The result then shows up at the next `done`: a wrong accumulator value, a wrong `done` spacing, or a spurious `illegal`. A RAM write to the wrong address, or a bad pointer lookup, stays hidden until a later instruction reads that location into the accumulator. The stimulus therefore mixes a full RAM initialisation, dense reads back into A, a post-reset sweep of stored values, and a random stream biased toward the register window.

// File: rtl/movcore.sv
module movcore #(
  parameter int CPB  = 12,
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] rom_addr,
  input  logic [7:0]      rom_data,
  output logic [7:0]      acc,
  output logic            done,
  output logic            illegal
);
  localparam int CW = (CPB > 1) ? $clog2(CPB) : 1;

  typedef enum logic [2:0] {S_ACC, S_REG, S_IND, S_DIR, S_IMM} src_t;
  typedef enum logic [2:0] {D_NONE, D_ACC, D_REG, D_IND, D_DIR} dst_t;

  logic [CW-1:0]   cnt;
  logic [PC_W-1:0] pc;
  logic            opnd_ph;
  logic [7:0]      ir;
  logic [7:0]      ram [256];
  src_t            src;
  dst_t            dst;
  logic            two, legal;
  logic [7:0]      val, waddr;

  wire       last = (cnt == CW'(CPB - 1));
  wire       take = last && !rst;
  wire [7:0] op   = opnd_ph ? ir : rom_data;
  wire       exec = take && (opnd_ph || !two);
  wire [7:0] rn   = {5'b0, op[2:0]};
  wire [7:0] ptr  = ram[{7'b0, op[0]}];
  wire       wram = (dst == D_REG) || (dst == D_IND) || (dst == D_DIR);

  assign rom_addr = take ? pc + 1'b1 : pc;

  always_comb begin
    src   = S_ACC;
    dst   = D_NONE;
    two   = 1'b0;
    legal = 1'b1;
    casez (op)
      8'b11101???: begin src = S_REG; dst = D_ACC; end
      8'b01111???: begin src = S_IMM; dst = D_REG; two = 1'b1; end
      8'b10101???: begin src = S_DIR; dst = D_REG; two = 1'b1; end
      8'b10001???: begin src = S_REG; dst = D_DIR; two = 1'b1; end
      8'b11111???: begin src = S_ACC; dst = D_REG; end
      8'b1111011?: begin src = S_ACC; dst = D_IND; end
      8'b1010011?: begin src = S_DIR; dst = D_IND; two = 1'b1; end
      8'b1110011?: begin src = S_IND; dst = D_ACC; end
      8'b1000011?: begin src = S_IND; dst = D_DIR; two = 1'b1; end
      8'h74:       begin src = S_IMM; dst = D_ACC; two = 1'b1; end
      8'hE5:       begin src = S_DIR; dst = D_ACC; two = 1'b1; end
      8'hF5:       begin src = S_ACC; dst = D_DIR; two = 1'b1; end
      default:     legal = 1'b0;
    endcase
  end

  always_comb begin
    case (src)
      S_REG:   val = ram[rn];
      S_IND:   val = ram[ptr];
      S_DIR:   val = ram[rom_data];
      S_IMM:   val = rom_data;
      default: val = acc;
    endcase
    case (dst)
      D_REG:   waddr = rn;
      D_IND:   waddr = ptr;
      default: waddr = rom_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pc      <= '0;
      opnd_ph <= 1'b0;
      ir      <= 8'h00;
      acc     <= 8'h00;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done <= exec;
      cnt  <= last ? '0 : cnt + 1'b1;
      if (take) begin
        pc      <= pc + 1'b1;
        opnd_ph <= !opnd_ph && two;
        if (!opnd_ph) ir <= rom_data;
      end
      if (exec) begin
        if (dst == D_ACC) acc <= val;
        if (!legal) illegal <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (exec && wram) ram[waddr] <= val;
endmodule

// File: rtl/movcore_chk.sv
module movcore_chk #(
  parameter int CPB  = 12,
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] rom_addr,
  input logic [7:0]      acc,
  input logic            done,
  input logic            illegal
);
  logic            rst_d;
  logic [15:0]     gap;
  logic [PC_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    rst_d     <= rst;
    prev_addr <= rom_addr;
    if (rst)               gap <= '0;
    else if (done)         gap <= 16'd1;
    else if (gap != '1)    gap <= gap + 1'b1;
  end

  AST_BYTE_PACE: assert property (@(posedge clk) disable iff (rst || rst_d)
    done |-> gap >= 16'(CPB)); // R3
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst || rst_d)
    !$stable(rom_addr) |-> rom_addr == prev_addr + 1'b1); // R4
  AST_ILL_STICKY: assert property (@(posedge clk) disable iff (rst || rst_d)
    illegal |=> illegal); // R9
  AST_ACC_AT_DONE: assert property (@(posedge clk) disable iff (rst || rst_d)
    !$stable(acc) |-> done); // R10
endmodule

bind movcore movcore_chk #(.CPB(CPB), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .rom_addr(rom_addr),
  .acc(acc), .done(done), .illegal(illegal)
);

// File: tb/sim_movcore.sv
module sim_movcore;
  localparam int PW = 16;
  localparam int ROMN = 4096;
  localparam int EN = 2048;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst = 1'b1;

  logic [PW-1:0] ra0, ra1;
  logic [7:0] rd0, rd1, acc0, acc1;
  logic done0, done1, ill0, ill1;

  movcore #(.CPB(12), .PC_W(PW)) u0 (.clk(clk), .rst(rst), .rom_addr(ra0), .rom_data(rd0),
    .acc(acc0), .done(done0), .illegal(ill0));
  movcore #(.CPB(1), .PC_W(PW)) u1 (.clk(clk), .rst(rst), .rom_addr(ra1), .rom_data(rd1),
    .acc(acc1), .done(done1), .illegal(ill1));

  logic [7:0] rom [ROMN];
  always @(posedge clk) begin
    rd0 <= (int'(ra0) < ROMN) ? rom[ra0[11:0]] : 8'h00;
    rd1 <= (int'(ra1) < ROMN) ? rom[ra1[11:0]] : 8'h00;
  end

  logic [7:0] e_acc [EN];
  logic       e_ill [EN];
  int         e_len [EN];
  int         e_pc  [EN];
  string      e_tag [EN];
  int n_exp = 0;
  int lim = 0;

  logic [7:0] m_ram [256];
  logic [7:0] m_acc;
  logic       m_ill;
  int         m_pc;

  int checks = 0, errors = 0, cyc = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] op, input logic [7:0] b2, input string tag);
    int len;
    logic [7:0] p, n;
    len = 1;
    p = m_ram[{7'b0, op[0]}];
    n = {5'b0, op[2:0]};
    casez (op)
      8'b11101???: m_acc = m_ram[n];
      8'b01111???: begin len = 2; m_ram[n] = b2; end
      8'b10101???: begin len = 2; m_ram[n] = m_ram[b2]; end
      8'b10001???: begin len = 2; m_ram[b2] = m_ram[n]; end
      8'b11111???: m_ram[n] = m_acc;
      8'b1111011?: m_ram[p] = m_acc;
      8'b1010011?: begin len = 2; m_ram[p] = m_ram[b2]; end
      8'b1110011?: m_acc = m_ram[p];
      8'b1000011?: begin len = 2; m_ram[b2] = m_ram[p]; end
      8'h74:       begin len = 2; m_acc = b2; end
      8'hE5:       begin len = 2; m_acc = m_ram[b2]; end
      8'hF5:       begin len = 2; m_ram[b2] = m_acc; end
      default:     m_ill = 1'b1;
    endcase
    rom[m_pc] = op;
    if (len == 2) rom[m_pc + 1] = b2;
    m_pc += len;
    e_acc[n_exp] = m_acc;
    e_ill[n_exp] = m_ill;
    e_len[n_exp] = len;
    e_pc[n_exp]  = m_pc;
    e_tag[n_exp] = tag;
    n_exp++;
  endtask

  task automatic rnd_instr();
    int k;
    logic [2:0] n;
    logic i;
    logic [7:0] d, v;
    logic [7:0] bad [5];
    bad[0] = 8'h00; bad[1] = 8'h04; bad[2] = 8'h14; bad[3] = 8'h23; bad[4] = 8'hC3;
    k = $urandom % 13;
    n = 3'($urandom % 8);
    i = 1'($urandom % 2);
    d = ($urandom % 2) ? 8'($urandom % 16) : 8'($urandom % 256);
    v = 8'($urandom % 256);
    case (k)
      0:  put({5'b11101, n}, 8'h00, "R5");
      1:  put({5'b01111, n}, v, "R5");
      2:  put({5'b10101, n}, d, "R5");
      3:  put({5'b10001, n}, d, "R5");
      4:  put({5'b11111, n}, 8'h00, "R5");
      5:  put({7'b1111011, i}, 8'h00, "R6");
      6:  put({7'b1010011, i}, d, "R6");
      7:  put({7'b1110011, i}, 8'h00, "R6");
      8:  put({7'b1000011, i}, d, "R6");
      9:  put(8'h74, v, "R7");
      10: put(8'hE5, d, "R7");
      11: put(8'hF5, d, "R7");
      default: put(bad[$urandom % 5], 8'h00, "R9");
    endcase
  endtask

  task automatic clear_rom();
    for (int a = 0; a < ROMN; a++) rom[a] = 8'h00;
    m_pc = 0;
    m_acc = 8'h00;
    m_ill = 1'b0;
  endtask

  int idx0 = 0, tick0 = 0, last0 = -1;
  int idx1 = 0, tick1 = 0, last1 = -1;
  logic pd0 = 1'b0, pd1 = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      tick0 = 0; last0 = -1; pd0 = 1'b0;
    end else begin
      tick0++;
      if (done0 && idx0 < lim) begin
        chk(acc0 == e_acc[idx0], e_tag[idx0], "u0 acc", acc0, e_acc[idx0]);
        chk(ill0 == e_ill[idx0], "R9", "u0 illegal", ill0, e_ill[idx0]);
        chk(int'(ra0) == e_pc[idx0], "R4", "u0 rom_addr", ra0, e_pc[idx0]);
        chk(!pd0, "R10", "u0 done width", pd0, 0);
        if (last0 >= 0)
          chk(tick0 - last0 == 12 * e_len[idx0], "R3", "u0 spacing", tick0 - last0, 12 * e_len[idx0]);
        last0 = tick0;
        idx0++;
      end
      pd0 = done0;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      tick1 = 0; last1 = -1; pd1 = 1'b0;
    end else begin
      tick1++;
      if (done1 && idx1 < lim) begin
        chk(acc1 == e_acc[idx1], e_tag[idx1], "u1 acc", acc1, e_acc[idx1]);
        chk(ill1 == e_ill[idx1], "R9", "u1 illegal", ill1, e_ill[idx1]);
        if (last1 >= 0)
          chk(tick1 - last1 == e_len[idx1], "R3", "u1 spacing", tick1 - last1, e_len[idx1]);
        last1 = tick1;
        idx1++;
      end
    end
  end

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic reset_checks();
    @(negedge clk);
    chk(acc0 == 8'h00 && acc1 == 8'h00, "R1", "acc in reset", {acc0, acc1}, 0);
    chk(!ill0 && !ill1, "R1", "illegal in reset", {ill0, ill1}, 0);
    chk(!done0 && !done1, "R1", "done in reset", {done0, done1}, 0);
    chk(ra0 == '0 && ra1 == '0, "R1", "rom_addr in reset", ra0 | ra1, 0);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    clear_rom();
    for (int a = 0; a < 256; a++) begin
      put(8'h74, 8'($urandom % 256), "R7");
      put(8'hF5, 8'(a), "R7");
    end
    put(8'h74, 8'hA5, "R8");
    put(8'hF5, 8'h03, "R8");
    put(8'h74, 8'h00, "R8");
    put(8'hEB, 8'h00, "R8");
    put(8'h74, 8'h3C, "R8");
    put(8'hFE, 8'h00, "R8");
    put(8'h74, 8'h00, "R8");
    put(8'hE5, 8'h06, "R8");
    put(8'h78, 8'h10, "R6");
    put(8'hF6, 8'h00, "R6");
    put(8'hE5, 8'h10, "R6");
    put(8'h74, 8'h77, "R9");
    put(8'hC3, 8'h00, "R9");
    put(8'hE5, 8'h10, "R9");
    for (int k = 0; k < 200; k++) rnd_instr();
    lim = n_exp;
    repeat (3) @(posedge clk);
    reset_checks();
    rst = 1'b0;
    wait (idx0 >= lim && idx1 >= lim);
    @(posedge clk);
    rst = 1'b1;
    clear_rom();
    for (int k = 0; k < 8; k++) put(8'hE5, 8'(k), "R2");
    for (int k = 0; k < 8; k++) put(8'hE5, 8'($urandom % 256), "R2");
    for (int k = 0; k < 100; k++) rnd_instr();
    repeat (3) @(posedge clk);
    reset_checks();
    lim = n_exp;
    rst = 1'b0;
    wait (idx0 >= lim && idx1 >= lim);
    repeat (2) @(posedge clk);
    summary();
  end
endmodule